// File: doc/BRIEF.md
# Master clock ratio normalizer

This block runs in the master clock domain of a sampling converter. It compares the master clock with the frame-rate word clock and works out whether the master clock is 256, 384, 512 or 768 times the sample rate. From that it produces a clock enable that fires at a steady 256 times the sample rate, whatever the ratio. The converter core clocks on that enable.

The word clock enters asynchronously and passes through a two-stage synchronizer. Master clock cycles are counted between successive rising word-clock edges. Each frame count is classified against the four ratios with a tolerance of two cycles. The block leaves power-down only after two consecutive frames give the same ratio. It falls back to power-down in four cases: the power-down pin goes low, a frame disagrees with the locked ratio, a count falls outside every window, or no word-clock edge arrives within the timeout. The two clocks must be frequency-locked, but their relative phase does not matter.

Top module: `mclk_ratio_norm`

## Requirements
- R1: A frame of N master clocks, with N within ±2 of 256, 384, 512 or 768, locks to ratio code 0, 1, 2 or 3 respectively, and that code is shown on ratio_o while ready_o is high.
- R2: A frame count that lies outside all four tolerance windows never raises ready_o.
- R3: ready_o rises only after two consecutive measured frames give the same ratio. The first rising edge after power-down only starts a count, so the third rising edge is the earliest lock point. A first frame that disagrees with the second restarts the agreement check.
- R4: While ready_o is high, ce256_o fires on every master clock for code 0, on two of every three for code 1, on one of every two for code 2, and on one of every three for code 3. This gives exactly 256 pulses per frame in every mode.
- R5: While sleep_ni is low, ready_o, ce256_o and ratio_o stay at 0 whatever the clocks do. Two cycles after sleep_ni falls, all three read 0.
- R6: While ready_o is high, a frame whose ratio differs from the locked one drops ready_o. The block then needs two fresh agreeing frames to lock again.
- R7: If no word-clock rising edge arrives within 1024 master clocks, ready_o drops.
- R8: After reset, ready_o, ce256_o and ratio_o are 0. Whenever ready_o is low, ratio_o reads 0 and ce256_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wclk_i | input | 1 | Frame-rate word clock, asynchronous |
| sleep_ni | input | 1 | Active-low power-down request |
| ce256_o | output | 1 | Clock enable at 256 times the sample rate |
| ratio_o | output | 2 | Locked ratio: 0=256, 1=384, 2=512, 3=768 |
| ready_o | output | 1 | Lock achieved, converter core may run |

## Verification
The bench targets the edges of the ±2 tolerance windows: 254, 258, 386 and 770 must lock, while 259 and 300 must not. A comparator that is off by one, or a counter that miscounts by one cycle, moves a window and either locks on 259 or rejects 258. The bench also counts enables over a 1536-cycle window in each mode. A wrong 2/3 pattern, or a divider that is not reset on lock, gives a count other than 256 per frame. It further checks that a single agreeing measurement does not lock and that a first disagreeing frame is discarded. Finally, it checks that a mismatch or a missing edge drops ready_o; a design that only ever latches lock would stay high.

// File: rtl/mrn_pkg.sv
package mrn_pkg;

  typedef enum logic [1:0] {
    RATIO_256 = 2'd0,
    RATIO_384 = 2'd1,
    RATIO_512 = 2'd2,
    RATIO_768 = 2'd3
  } ratio_e;

  typedef struct packed {
    logic   ok;
    ratio_e code;
  } class_t;

  // ratio expressed in half-steps of the base rate: 2, 3, 4, 6
  function automatic int unsigned half_mult(int unsigned k);
    case (k)
      0: return 2;
      1: return 3;
      2: return 4;
      default: return 6;
    endcase
  endfunction

  // classify a frame length in master clocks against the four ratios
  function automatic class_t classify(int unsigned cnt, int unsigned base,
                                      int unsigned tol);
    class_t r;
    r.ok   = 1'b0;
    r.code = RATIO_256;
    for (int k = 0; k < 4; k++) begin
      int unsigned tgt;
      tgt = (base * half_mult(k)) / 2;
      if ((cnt + tol >= tgt) && (cnt <= tgt + tol)) begin
        r.ok   = 1'b1;
        r.code = ratio_e'(k[1:0]);
      end
    end
    return r;
  endfunction

  // length of the enable pattern for each ratio
  function automatic logic [1:0] pattern_len(ratio_e r);
    case (r)
      RATIO_256: return 2'd1;
      RATIO_512: return 2'd2;
      default:   return 2'd3;
    endcase
  endfunction

  // does the enable fire at this position of the pattern
  function automatic logic pattern_hit(ratio_e r, logic [1:0] ph);
    case (r)
      RATIO_256: return 1'b1;
      RATIO_384: return ph != 2'd2;
      default:   return ph == 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/mrn_edge_sync.sv
module mrn_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  assert_single_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mrn_period_meter.sv
module mrn_period_meter #(
  parameter int unsigned TIMEOUT = 1024,
  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic             meas_valid_o,
  output logic [CNT_W-1:0] meas_cnt_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q  <= SAT;
      seen_q <= 1'b0;
    end else if (cnt_q != SAT) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign meas_valid_o = rise_i & seen_q;
  assign meas_cnt_o   = cnt_q + CNT_W'(1);
  assign timeout_o    = ~rise_i & (cnt_q == LAST);

  assert_timeout_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  assert_no_meas_after_timeout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !meas_valid_o);
endmodule

// File: rtl/mrn_lock_fsm.sv
module mrn_lock_fsm
  import mrn_pkg::*;
#(
  parameter int unsigned BASE  = 256,
  parameter int unsigned TOL   = 2,
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_ni,
  input  logic             meas_valid_i,
  input  logic [CNT_W-1:0] meas_cnt_i,
  input  logic             timeout_i,
  output logic             ready_o,
  output ratio_e           ratio_o
);
  typedef enum logic [1:0] {ST_DOWN, ST_ACQ, ST_RUN} state_e;

  state_e st_q;
  ratio_e held_q;
  class_t cls_w;

  assign cls_w = classify(32'(meas_cnt_i), BASE, TOL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_DOWN;
      held_q <= RATIO_256;
    end else if (!sleep_ni || timeout_i) begin
      st_q <= ST_DOWN;
    end else if (meas_valid_i) begin
      case (st_q)
        ST_DOWN: if (cls_w.ok) begin
          st_q   <= ST_ACQ;
          held_q <= cls_w.code;
        end
        ST_ACQ: begin
          if (!cls_w.ok)                 st_q   <= ST_DOWN;
          else if (cls_w.code == held_q) st_q   <= ST_RUN;
          else                           held_q <= cls_w.code;
        end
        default: if (!cls_w.ok || cls_w.code != held_q) st_q <= ST_DOWN;
      endcase
    end
  end

  assign ready_o = (st_q == ST_RUN);
  assign ratio_o = ready_o ? held_q : RATIO_256;

  assert_lock_on_measure_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(meas_valid_i));
  assert_mismatch_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && meas_valid_i && cls_w.code != ratio_o) |=> !ready_o);
  assert_ratio_steady_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |-> $stable(ratio_o));
endmodule

// File: rtl/mrn_ce_gen.sv
module mrn_ce_gen
  import mrn_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ready_i,
  input  ratio_e ratio_i,
  output logic   ce_o
);
  logic [1:0] ph_q;
  logic [1:0] wrap_w;

  assign wrap_w = pattern_len(ratio_i) - 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ph_q <= '0;
    else if (!ready_i)        ph_q <= '0;
    else if (ph_q == wrap_w)  ph_q <= '0;
    else                      ph_q <= ph_q + 2'd1;
  end

  assign ce_o = ready_i & pattern_hit(ratio_i, ph_q);

  assert_quiet_when_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> !ce_o);
  assert_half_rate_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && ratio_i == RATIO_512 && ce_o) |=> !ce_o);
  assert_third_rate_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && ratio_i == RATIO_768 && ce_o) |=> !ce_o);
  assert_two_thirds_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && ratio_i == RATIO_384 && !ce_o) |=> (ce_o || !ready_i));
endmodule

// File: rtl/mclk_ratio_norm.sv
module mclk_ratio_norm
  import mrn_pkg::*;
#(
  parameter int unsigned BASE    = 256,
  parameter int unsigned TOL     = 2,
  parameter int unsigned TIMEOUT = 1024,
  parameter int unsigned STAGES  = 2,
  localparam int unsigned CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wclk_i,
  input  logic       sleep_ni,
  output logic       ce256_o,
  output logic [1:0] ratio_o,
  output logic       ready_o
);
  logic             rise_w;
  logic             meas_valid_w;
  logic [CNT_W-1:0] meas_cnt_w;
  logic             timeout_w;
  logic             ready_w;
  ratio_e           ratio_w;

  mrn_edge_sync #(.STAGES(STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (wclk_i),
    .rise_o  (rise_w)
  );

  mrn_period_meter #(.TIMEOUT(TIMEOUT)) u_meter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rise_i       (rise_w),
    .meas_valid_o (meas_valid_w),
    .meas_cnt_o   (meas_cnt_w),
    .timeout_o    (timeout_w)
  );

  mrn_lock_fsm #(.BASE(BASE), .TOL(TOL), .CNT_W(CNT_W)) u_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_ni     (sleep_ni),
    .meas_valid_i (meas_valid_w),
    .meas_cnt_i   (meas_cnt_w),
    .timeout_i    (timeout_w),
    .ready_o      (ready_w),
    .ratio_o      (ratio_w)
  );

  mrn_ce_gen u_ce (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (ready_w),
    .ratio_i (ratio_w),
    .ce_o    (ce256_o)
  );

  assign ready_o = ready_w;
  assign ratio_o = ratio_w;

  assert_sleep_forces_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_ni |=> (!ready_o && !ce256_o));
  assert_timeout_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_w |=> !ready_o);
endmodule

// File: tb/mclk_ratio_norm_tb.sv
`timescale 1ns/1ps
module mclk_ratio_norm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wclk = 1'b0;
  logic       sleep_n = 1'b0;
  logic       ce;
  logic [1:0] ratio;
  logic       ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mclk_ratio_norm dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wclk_i   (wclk),
    .sleep_ni (sleep_n),
    .ce256_o  (ce),
    .ratio_o  (ratio),
    .ready_o  (ready)
  );

  // period, expected lock, expected code
  localparam int NV = 10;
  localparam int VEC [NV][3] = '{
    '{256, 1, 0}, '{384, 1, 1}, '{512, 1, 2}, '{768, 1, 3},
    '{254, 1, 0}, '{258, 1, 0}, '{386, 1, 1}, '{770, 1, 3},
    '{259, 0, 0}, '{300, 0, 0}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frames(int p, int n);
    for (int f = 0; f < n; f++) begin
      wclk = 1'b1; tick(p / 2);
      wclk = 1'b0; tick(p - p / 2);
    end
  endtask

  task automatic count_ce(int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (ce) c++;
    end
  endtask

  // power-down long enough for the meter to forget the last edge
  task automatic restart();
    sleep_n = 1'b0; wclk = 1'b0;
    tick(1100);
    sleep_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c;
    tick(3);
    chk("R8 ready in reset", ready, 0);
    rst_n = 1'b1;
    tick(2);
    chk("R8 ready after reset", ready, 0);
    chk("R8 ratio after reset", ratio, 0);
    chk("R8 ce after reset", ce, 0);

    // table walk: R1 lock and code, R2 rejection, R4 enable density
    for (int v = 0; v < NV; v++) begin
      int p;
      p = VEC[v][0];
      restart();
      frames(p, 4);
      chk($sformatf("R1/R2 ready period %0d", p), ready, VEC[v][1]);
      chk($sformatf("R1 ratio period %0d", p), ratio, VEC[v][2]);
      if (VEC[v][1] == 1) begin
        fork
          frames(p, 1536 / p + 1);
          count_ce(1536, c);
        join
        chk($sformatf("R4 enables in 1536 cycles period %0d", p), c,
            (1536 * 256) / (128 * (2 + (VEC[v][2] == 3 ? 4 : VEC[v][2]))));
      end else begin
        chk($sformatf("R8 ce idle period %0d", p), ce, 0);
      end
    end

    // R3: one measurement is not enough, third edge locks
    restart();
    frames(256, 2);
    chk("R3 ready after two edges", ready, 0);
    frames(256, 1);
    chk("R3 ready after three edges", ready, 1);
    // R3: disagreeing first frame is discarded
    restart();
    frames(256, 1);
    frames(512, 2);
    chk("R3 no lock on disagreeing pair", ready, 0);
    frames(512, 1);
    chk("R3 lock after agreeing pair", ready, 1);
    chk("R3 ratio after agreeing pair", ratio, 2);

    // R5: sleep low prevents lock and forces outputs down
    sleep_n = 1'b0; wclk = 1'b0; tick(1100);
    frames(256, 4);
    chk("R5 no lock while asleep", ready, 0);
    chk("R5 ce while asleep", ce, 0);
    sleep_n = 1'b1;
    frames(768, 4);
    chk("R5 lock after wake", ready, 1);
    sleep_n = 1'b0;
    tick(2);
    chk("R5 ready after sleep", ready, 0);
    chk("R5 ratio after sleep", ratio, 0);
    chk("R5 ce after sleep", ce, 0);

    // R6: mismatch drops, relock needs two fresh frames
    restart();
    frames(256, 4);
    chk("R6 locked at 256", ready, 1);
    frames(384, 2);
    chk("R6 drop on mismatch", ready, 0);
    frames(384, 2);
    chk("R6 relock", ready, 1);
    chk("R6 relock ratio", ratio, 1);

    // R7: missing word clock edge
    restart();
    frames(512, 4);
    tick(400);
    chk("R7 still ready before timeout", ready, 1);
    tick(700);
    chk("R7 ready after timeout", ready, 0);
    chk("R7 ce after timeout", ce, 0);

    finish_run();
  end
endmodule